// File: doc/BRIEF.md
# Systolic Montgomery Multiplier Row

This block forms the Montgomery product X·Y·2^-k mod M for an odd modulus M, where k = E·W. It uses the multiple-word radix-2 method on a linear row of N processing elements (PEs). Each PE handles one multiplier bit per pass. It streams the W-bit words of Y, M and the running sum S, one word per clock. Stage j in a pass works on bit pass·N + j of X, so each trip along the row consumes N consecutive multiplier bits. Words move between neighbouring stages with a fixed skew of two clocks. S leaves the last stage and goes into a small word store inside the block. From there it returns to the first stage for the next pass, and on the first pass a zero is used in its place.

The block reads the operand words itself. It places a word index on `op_addr` and expects the matching Y and M words back in the same cycle. Multiplier bits are fetched the same way through `x_idx` and `x_bit`. A `start` pulse launches a run. During the last pass, the result words leave the final stage on a write port. `done` pulses once the top word has been written. N must divide E and satisfy 2N ≤ E. Under these limits the top result word comes straight out of the last stage, and the recirculated sum is never read before it has been written.

The caller guarantees that M is odd, that M < 2^(k-2), and that X, Y < M. The result is returned without a final subtraction.

Top module: `mont_pe_row`

## Requirements
- R1: The result written during a run is congruent to X·Y·2^-k modulo M, with k = E·W.
- R2: The result is below 2M, and the carry out of the top word in every PE is zero.
- R3: `done` is high for exactly one cycle. It first rises (E·W/N)·E + 2N clock edges after the edge that samples `start`.
- R4: Each run writes exactly E result words on `res_we`/`res_addr`/`res_data`, with word 0 being least significant. `done` rises in the cycle after word E-1 is written.
- R5: A `start` pulse while a run is feeding is ignored. The run keeps its latency and its result.
- R6: After reset and before any `start`, `done`, `res_we` and `x_rd` are all low.
- R7: The sum is cleared at every start, so a zero multiplier gives an all-zero result even right after a run with other operands.
- R8: During one run, `x_rd` requests the multiplier bits 0 to k-1 exactly once each, in ascending order. Within a pass, successive requests are two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, ignored while busy |
| op_addr | output | $clog2(E) | Word index of the Y and M read |
| y_word | input | W | Y word at `op_addr`, same cycle |
| m_word | input | W | M word at `op_addr`, same cycle |
| x_rd | output | 1 | Multiplier bit request |
| x_idx | output | $clog2(E·W) | Index of the requested multiplier bit |
| x_bit | input | 1 | Multiplier bit at `x_idx`, same cycle |
| res_we | output | 1 | Result word write strobe |
| res_addr | output | $clog2(E) | Result word index |
| res_data | output | W | Result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Three rows with N of 1, 2 and 4 receive the same operands. They must agree with a reference that reduces X·Y mod M and then halves modulo M k times, so a scheduling fault in one stage count stands out against the others. Random 126-bit odd moduli exercise general carry paths. A modulus at its upper bound with X = Y = M-1 drives the carries and the top-word headroom to their limits. The modulus 3 with tiny operands exposes any error in the quotient bit of word 0. A zero multiplier placed right after a nonzero run shows whether the recirculated sum is really cleared. A second start issued in the middle of a run must leave the result and the latency untouched.

// File: rtl/mont_pe_row.sv
module mont_pe_row #(
  parameter int W = 16,
  parameter int E = 8,
  parameter int N = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic [$clog2(E)-1:0]   op_addr,
  input  logic [W-1:0]           y_word,
  input  logic [W-1:0]           m_word,
  output logic                   x_rd,
  output logic [$clog2(E*W)-1:0] x_idx,
  input  logic                   x_bit,
  output logic                   res_we,
  output logic [$clog2(E)-1:0]   res_addr,
  output logic [W-1:0]           res_data,
  output logic                   done
);
  localparam int K  = E * W;
  localparam int P  = K / N;
  localparam int AW = $clog2(E);
  localparam int XW = $clog2(K);
  localparam int PW = (P > 1) ? $clog2(P) : 1;

  logic          run;
  logic [PW-1:0] pass;
  logic [AW-1:0] word;
  logic          feed_last;

  assign feed_last = (pass == PW'(P - 1)) && (word == AW'(E - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pass <= '0;
      word <= '0;
    end else if (!run) begin
      if (start) begin
        run  <= 1'b1;
        pass <= '0;
        word <= '0;
      end
    end else begin
      word <= (word == AW'(E - 1)) ? '0 : word + 1'b1;
      if (word == AW'(E - 1)) pass <= pass + 1'b1;
      if (feed_last) run <= 1'b0;
    end
  end

  assign op_addr = word;
  assign x_rd    = run && !word[0] && ((word >> 1) < AW'(N));
  assign x_idx   = XW'(pass) * XW'(N) + XW'(word >> 1);

  logic          v_i   [0:N];
  logic          lst_i [0:N];
  logic [AW-1:0] ix_i  [0:N];
  logic [W-1:0]  y_i   [0:N-1];
  logic [W-1:0]  m_i   [0:N-1];
  logic [W-1:0]  s_i   [0:N-1];
  logic [W-1:0]  s_o   [0:N-1];

  logic [W-1:0] smem [0:E-1];
  logic [W-1:0] s_rd;

  assign s_rd = (v_i[N] && ix_i[N] == word) ? s_o[N-1] : smem[word];

  always_ff @(posedge clk)
    if (v_i[N]) smem[ix_i[N]] <= s_o[N-1];

  assign v_i[0]   = run;
  assign lst_i[0] = (pass == PW'(P - 1));
  assign ix_i[0]  = word;
  assign y_i[0]   = y_word;
  assign m_i[0]   = m_word;
  assign s_i[0]   = (pass == '0) ? '0 : s_rd;

  for (genvar k = 0; k < N; k++) begin : gen_stage
    logic           w0, xc, qn;
    logic [W+1:0]   t0, t;
    logic [W-1:0]   hold;
    logic [1:0]     cy;
    logic           q, xr;
    logic           va, vb, la, lb;
    logic [AW-1:0]  ia, ib;

    assign w0 = v_i[k] && (ix_i[k] == '0);
    assign xc = (ix_i[k] == '0) ? x_bit : xr;
    assign t0 = {2'b00, s_i[k]} + (xc ? {2'b00, y_i[k]} : '0);
    assign qn = w0 ? t0[0] : q;
    assign t  = t0 + (qn ? {2'b00, m_i[k]} : '0) + (w0 ? '0 : {W'(0), cy});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold <= '0;
        cy   <= '0;
        q    <= 1'b0;
        xr   <= 1'b0;
        s_o[k] <= '0;
      end else begin
        if (v_i[k]) begin
          hold <= t[W-1:0];
          cy   <= t[W+1:W];
          q    <= qn;
          if (w0) xr <= x_bit;
        end
        s_o[k] <= (v_i[k] && !w0) ? {t[0], hold[W-1:1]} : {cy[0], hold[W-1:1]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        va <= 1'b0; vb <= 1'b0;
        la <= 1'b0; lb <= 1'b0;
        ia <= '0;   ib <= '0;
      end else begin
        va <= v_i[k];   vb <= va;
        la <= lst_i[k]; lb <= la;
        ia <= ix_i[k];  ib <= ia;
      end
    end

    assign v_i[k+1]   = vb;
    assign lst_i[k+1] = lb;
    assign ix_i[k+1]  = ib;

    if (k < N - 1) begin : gen_ym
      logic [W-1:0] ya, yb, ma, mb;
      always_ff @(posedge clk) begin
        ya <= y_i[k]; yb <= ya;
        ma <= m_i[k]; mb <= ma;
      end
      assign y_i[k+1] = yb;
      assign m_i[k+1] = mb;
      assign s_i[k+1] = s_o[k];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i[k] && ix_i[k] == AW'(E - 1)) |=> (cy[1] == 1'b0)); // R2
  end

  assign res_we   = v_i[N] && lst_i[N];
  assign res_addr = ix_i[N];
  assign res_data = s_o[N-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) done <= 1'b0;
    else        done <= res_we && (res_addr == AW'(E - 1));

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_AFTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_we && res_addr == AW'(E - 1))); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && word != AW'(E - 1)) |=> (run && word == $past(word) + 1'b1)); // R5

  AST_XIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd && $past(x_rd, 2)) |-> (x_idx == $past(x_idx, 2) + 1'b1)); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |-> !x_rd); // R6
endmodule

// File: tb/tb_mont_pe_row.sv
module tb_mont_pe_row;
  localparam int W = 16;
  localparam int E = 8;
  localparam int K = E * W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clr = 1'b0;
  logic [K-1:0] xv = '0, yv = '0, mv = '0;
  integer cyc = 0;
  integer checks = 0;
  integer fails = 0;
  integer c0 = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar gi = 0; gi < 3; gi++) begin : g
    localparam int NN = 1 << gi;
    logic [$clog2(E)-1:0] op_addr, res_addr;
    logic [W-1:0] y_word, m_word, res_data;
    logic x_rd, x_bit, res_we, done;
    logic [$clog2(K)-1:0] x_idx;

    assign y_word = yv[int'(op_addr) * W +: W];
    assign m_word = mv[int'(op_addr) * W +: W];
    assign x_bit  = xv[x_idx];

    mont_pe_row #(.W(W), .E(E), .N(NN)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .op_addr(op_addr), .y_word(y_word), .m_word(m_word),
      .x_rd(x_rd), .x_idx(x_idx), .x_bit(x_bit),
      .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
      .done(done)
    );

    logic [K-1:0] res = '0;
    integer nd = 0, nwe = 0, nx = 0, xbad = 0, dcyc = -1, last_addr = -1;
    bit top_ok = 1'b0;

    always @(negedge clk) begin
      if (clr) begin
        res = '0; nd = 0; nwe = 0; nx = 0; xbad = 0; dcyc = -1; last_addr = -1; top_ok = 1'b0;
      end else begin
        if (done) begin
          nd = nd + 1;
          if (dcyc < 0) dcyc = cyc;
          top_ok = (last_addr == E - 1);
        end
        if (res_we) begin
          res[int'(res_addr) * W +: W] = res_data;
          nwe = nwe + 1;
          last_addr = int'(res_addr);
        end
        if (x_rd) begin
          if (int'(x_idx) != nx) xbad = xbad + 1;
          nx = nx + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mont_ref(input logic [K-1:0] x, input logic [K-1:0] y, input logic [K-1:0] m);
    logic [255:0] r;
    r = ({128'b0, x} * {128'b0, y}) % {128'b0, m};
    for (int i = 0; i < K; i++) begin
      if (r[0]) r = r + {128'b0, m};
      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [K-1:0] rnd_wide();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk_inst(input int nn, input logic [K-1:0] r, input int nd, input int nwe,
                          input int nx, input int xbad, input int dcyc, input bit top_ok, input bit busy);
    logic [255:0] exp;
    int lat;
    exp = mont_ref(xv, yv, mv);
    lat = (K / nn) * E + 2 * nn;
    chk(({128'b0, r} % {128'b0, mv}) == exp, "R1 residue", {128'b0, r}, exp);
    chk({128'b0, r} < ({128'b0, mv} << 1), "R2 below 2M", {128'b0, r}, {128'b0, mv} << 1);
    chk(dcyc - c0 == lat, busy ? "R5 latency with extra start" : "R3 latency", 256'(dcyc - c0), 256'(lat));
    chk(nd == 1, "R3 single done pulse", 256'(nd), 256'd1);
    chk(nwe == E && top_ok, "R4 write count and top word last", 256'(nwe), 256'(E));
    chk(nx == K && xbad == 0, "R8 bit request order", 256'(nx + xbad), 256'(K));
    if (xv == '0) chk(r == '0, "R7 zero multiplier", {128'b0, r}, 256'd0);
  endtask

  task automatic run_vec(input logic [K-1:0] x, input logic [K-1:0] y, input logic [K-1:0] m, input bit busy);
    int t;
    @(posedge clk); #1;
    xv = x; yv = y; mv = m; clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    c0 = cyc; start = 1'b0;
    if (busy) begin
      repeat (20) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    t = 0;
    while (!(g[0].nd > 0 && g[1].nd > 0 && g[2].nd > 0) && t < 3000) begin
      @(posedge clk); t++;
    end
    if (t >= 3000) chk(1'b0, "R3 watchdog expired", 256'(t), 256'd0);
    repeat (4) @(posedge clk);
    chk_inst(1, g[0].res, g[0].nd, g[0].nwe, g[0].nx, g[0].xbad, g[0].dcyc, g[0].top_ok, busy);
    chk_inst(2, g[1].res, g[1].nd, g[1].nwe, g[1].nx, g[1].xbad, g[1].dcyc, g[1].top_ok, busy);
    chk_inst(4, g[2].res, g[2].nd, g[2].nwe, g[2].nx, g[2].xbad, g[2].dcyc, g[2].top_ok, busy);
  endtask

  task automatic run_rand(input bit busy);
    logic [K-1:0] m;
    m = rnd_wide();
    m[K-1:K-2] = 2'b00;
    m[0] = 1'b1;
    if (m < 3) m = 3;
    run_vec(rnd_wide() % m, rnd_wide() % m, m, busy);
  endtask

  initial begin
    logic [K-1:0] mtop;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!g[0].done && !g[1].done && !g[2].done, "R6 done idle", 256'({g[2].done, g[1].done, g[0].done}), 256'd0);
    chk(!g[0].res_we && !g[1].res_we && !g[2].res_we, "R6 write idle", 256'({g[2].res_we, g[1].res_we, g[0].res_we}), 256'd0);
    chk(!g[0].x_rd && !g[1].x_rd && !g[2].x_rd, "R6 request idle", 256'({g[2].x_rd, g[1].x_rd, g[0].x_rd}), 256'd0);

    run_rand(1'b0);
    run_vec('0, yv, mv, 1'b0);
    mtop = {2'b00, {(K-2){1'b1}}};
    run_vec(mtop - 1, mtop - 1, mtop, 1'b0);
    run_vec(K'(2), K'(2), K'(3), 1'b0);
    run_rand(1'b1);
    for (int i = 0; i < 5; i++) run_rand(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL R3 global watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule